// File: doc/BRIEF.md
# Bidirectional Byte Parity Checker and Generator

This block sits beside an 8-bit path that joins two buses, side A and side B. Each bus has its own parity line. Two active-low direction enables, a function select and a parity-sense select pick one of seven operating modes. In these modes the block checks the parity of one or both sides, forwards a parity bit across the path, or drives fresh parity onto both buses. It is purely combinational. Every driven output has its own enable output, which stands in for a tri-state pad. When an enable is low, the output value is held at 0.

The select lines decode into these named modes:
- MODE_CHK_AB: function select low, A-to-B enable low, B-to-A enable high.
- MODE_CHK_BA: function select low, A-to-B enable high, B-to-A enable low.
- MODE_CHK_BOTH: function select low, both enables high.
- MODE_GEN: function select low, both enables low.
- MODE_PASS_AB: function select high, A-to-B enable low, B-to-A enable high.
- MODE_PASS_BA: function select high, A-to-B enable high, B-to-A enable low.
- MODE_IDLE: function select high, both enables at the same level.

A change on any select line moves the block straight to the mode those lines decode to. There is no ordering between modes and no history. A check flag is high when the side is good. It is low when the count of ones in the eight data bits plus that side's parity bit does not have the selected sense.

Top module: `bpar_xcvr`

## Requirements
- R1: With `odd_sel` = 0, every driven check flag is 1 when the ones-count of its side's data plus its parity input is even, and 0 otherwise.
- R2: With `odd_sel` = 1, every driven check flag is 1 when that sum is odd, and 0 otherwise.
- R3: In MODE_CHK_AB (`func_sel_n`=0, `a2b_en_n`=0, `b2a_en_n`=1), the block drives the A flag (`chk_a_oe`=1) and leaves the B flag undriven (`chk_b_oe`=0). It drives `par_b_out` = `par_a` with `par_b_oe`=1, and `par_a_oe`=0.
- R4: In MODE_CHK_BA (`func_sel_n`=0, `a2b_en_n`=1, `b2a_en_n`=0), the block drives the B flag and leaves the A flag undriven. It drives `par_a_out` = `par_b` with `par_a_oe`=1, and `par_b_oe`=0.
- R5: In MODE_CHK_BOTH (`func_sel_n`=0, both enables 1), both flags are driven, each one from its own side's data and parity input. Neither parity output is driven.
- R6: In MODE_GEN (`func_sel_n`=0, both enables 0), both parity outputs are driven. Each one takes the level that gives its own bus even parity (`odd_sel`=0) or odd parity (`odd_sel`=1). Neither flag is driven.
- R7: With `func_sel_n`=1, no flag is driven. In a single-direction transfer the destination parity output is driven with the source parity input. When both enables are at the same level, no parity output is driven.
- R8: Any output whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_a | input | 8 | Side A data bits |
| par_a | input | 1 | Side A parity line as received |
| data_b | input | 8 | Side B data bits |
| par_b | input | 1 | Side B parity line as received |
| a2b_en_n | input | 1 | Active-low enable for the A-to-B direction |
| b2a_en_n | input | 1 | Active-low enable for the B-to-A direction |
| func_sel_n | input | 1 | Low selects the parity functions; high selects plain forwarding |
| odd_sel | input | 1 | 0 selects even parity sense, 1 selects odd parity sense |
| par_a_out | output | 1 | Parity value driven onto side A |
| par_a_oe | output | 1 | Drive enable for par_a_out |
| par_b_out | output | 1 | Parity value driven onto side B |
| par_b_oe | output | 1 | Drive enable for par_b_out |
| chk_a_n | output | 1 | Side A check flag, low on a parity error |
| chk_a_oe | output | 1 | Drive enable for chk_a_n |
| chk_b_n | output | 1 | Side B check flag, low on a parity error |
| chk_b_oe | output | 1 | Drive enable for chk_b_n |

## Verification
The hardest case to reach is MODE_CHK_BOTH with the two sides disagreeing. One flag must report good while the other reports an error, which shows that each flag reads only its own side. The stimulus keeps side B's data as a scrambled copy of side A's and steps the two parity inputs independently. Both the same-verdict and the split-verdict cases then occur for every data value. The sweep covers all 256 A patterns, both parity-input values on each side, both senses, and all eight settings of the select lines. Every output is compared on every clock.

// File: rtl/bpar_pkg.sv
package bpar_pkg;

    typedef enum logic [2:0] {
        MODE_CHK_AB,
        MODE_CHK_BA,
        MODE_CHK_BOTH,
        MODE_GEN,
        MODE_PASS_AB,
        MODE_PASS_BA,
        MODE_IDLE
    } bpar_mode_t;

endpackage

// File: rtl/bpar_side.sv
module bpar_side #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              par_in,
    input  logic              odd_sel,
    output logic              chk_n,
    output logic              gen_par
);
    logic data_odd;

    always_comb begin
        data_odd = ^data;
        // good when (data ones + parity bit) matches the selected sense
        chk_n    = ~(data_odd ^ par_in ^ odd_sel);
        // level that brings this bus to the selected sense
        gen_par  = data_odd ^ odd_sel;
    end
endmodule

// File: rtl/bpar_decode.sv
module bpar_decode
    import bpar_pkg::*;
(
    input  logic       a2b_en_n,
    input  logic       b2a_en_n,
    input  logic       func_sel_n,
    output bpar_mode_t mode
);
    always_comb begin
        unique case ({func_sel_n, a2b_en_n, b2a_en_n})
            3'b001:  mode = MODE_CHK_AB;
            3'b010:  mode = MODE_CHK_BA;
            3'b011:  mode = MODE_CHK_BOTH;
            3'b000:  mode = MODE_GEN;
            3'b101:  mode = MODE_PASS_AB;
            3'b110:  mode = MODE_PASS_BA;
            3'b100:  mode = MODE_IDLE;
            3'b111:  mode = MODE_IDLE;
            default: mode = MODE_IDLE;
        endcase
    end
endmodule

// File: rtl/bpar_xcvr.sv
module bpar_xcvr
    import bpar_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data_a,
    input  logic              par_a,
    input  logic [DATA_W-1:0] data_b,
    input  logic              par_b,
    input  logic              a2b_en_n,
    input  logic              b2a_en_n,
    input  logic              func_sel_n,
    input  logic              odd_sel,
    output logic              par_a_out,
    output logic              par_a_oe,
    output logic              par_b_out,
    output logic              par_b_oe,
    output logic              chk_a_n,
    output logic              chk_a_oe,
    output logic              chk_b_n,
    output logic              chk_b_oe
);
    bpar_mode_t mode;
    logic       a_chk_n, a_gen, b_chk_n, b_gen;
    logic       pa_v, pb_v, ca_v, cb_v;

    bpar_decode u_dec (
        .a2b_en_n  (a2b_en_n),
        .b2a_en_n  (b2a_en_n),
        .func_sel_n(func_sel_n),
        .mode      (mode)
    );

    bpar_side #(.DATA_W(DATA_W)) u_side_a (
        .data   (data_a),
        .par_in (par_a),
        .odd_sel(odd_sel),
        .chk_n  (a_chk_n),
        .gen_par(a_gen)
    );

    bpar_side #(.DATA_W(DATA_W)) u_side_b (
        .data   (data_b),
        .par_in (par_b),
        .odd_sel(odd_sel),
        .chk_n  (b_chk_n),
        .gen_par(b_gen)
    );

    // output process: drive enables and raw values per mode
    always_comb begin
        par_a_oe = 1'b0; par_b_oe = 1'b0; chk_a_oe = 1'b0; chk_b_oe = 1'b0;
        pa_v     = 1'b0; pb_v     = 1'b0; ca_v     = 1'b0; cb_v     = 1'b0;
        unique case (mode)
            MODE_CHK_AB: begin
                chk_a_oe = 1'b1; ca_v = a_chk_n;
                par_b_oe = 1'b1; pb_v = par_a;
            end
            MODE_CHK_BA: begin
                chk_b_oe = 1'b1; cb_v = b_chk_n;
                par_a_oe = 1'b1; pa_v = par_b;
            end
            MODE_CHK_BOTH: begin
                chk_a_oe = 1'b1; ca_v = a_chk_n;
                chk_b_oe = 1'b1; cb_v = b_chk_n;
            end
            MODE_GEN: begin
                par_a_oe = 1'b1; pa_v = a_gen;
                par_b_oe = 1'b1; pb_v = b_gen;
            end
            MODE_PASS_AB: begin
                par_b_oe = 1'b1; pb_v = par_a;
            end
            MODE_PASS_BA: begin
                par_a_oe = 1'b1; pa_v = par_b;
            end
            MODE_IDLE: begin
            end
            default: begin
            end
        endcase
    end

    assign par_a_out = par_a_oe & pa_v;
    assign par_b_out = par_b_oe & pb_v;
    assign chk_a_n   = chk_a_oe & ca_v;
    assign chk_b_n   = chk_b_oe & cb_v;

    always_comb begin
        // R3, R4: a side never carries its own flag while its parity is driven
        if (par_a_oe) assert_a_side_excl_R3: assert (!chk_a_oe)
            else $error("R3: side A flag and parity both driven");
        if (par_b_oe) assert_b_side_excl_R4: assert (!chk_b_oe)
            else $error("R4: side B flag and parity both driven");
        // R1, R2: a driven A flag agrees with the side's total parity
        if (chk_a_oe) assert_chk_a_sense_R1: assert (chk_a_n == (($countones({data_a, par_a}) % 2 == 1) == odd_sel))
            else $error("R1: side A flag wrong");
        if (chk_b_oe) assert_chk_b_sense_R2: assert (chk_b_n == (($countones({data_b, par_b}) % 2 == 1) == odd_sel))
            else $error("R2: side B flag wrong");
        // R6: both parities driven means each bus reaches the selected sense
        if (par_a_oe && par_b_oe) assert_gen_sense_R6: assert (
            (($countones({data_a, par_a_out}) % 2 == 1) == odd_sel) &&
            (($countones({data_b, par_b_out}) % 2 == 1) == odd_sel))
            else $error("R6: generated parity wrong");
        // R7: forwarding mode drives no flag
        if (func_sel_n) assert_no_flag_fwd_R7: assert (!chk_a_oe && !chk_b_oe)
            else $error("R7: flag driven with function select high");
        // R8: undriven outputs read zero
        assert_quiet_zero_R8: assert ((par_a_oe || !par_a_out) && (par_b_oe || !par_b_out) &&
                                      (chk_a_oe || !chk_a_n) && (chk_b_oe || !chk_b_n))
            else $error("R8: undriven output not zero");
    end
endmodule

// File: tb/tb_bpar_xcvr.sv
module tb_bpar_xcvr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] data_a = '0, data_b = '0;
    logic       par_a = 1'b0, par_b = 1'b0;
    logic       a2b_en_n = 1'b0, b2a_en_n = 1'b0, func_sel_n = 1'b0, odd_sel = 1'b0;
    logic       par_a_out, par_a_oe, par_b_out, par_b_oe;
    logic       chk_a_n, chk_a_oe, chk_b_n, chk_b_oe;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    bpar_xcvr dut (
        .data_a(data_a), .par_a(par_a), .data_b(data_b), .par_b(par_b),
        .a2b_en_n(a2b_en_n), .b2a_en_n(b2a_en_n), .func_sel_n(func_sel_n),
        .odd_sel(odd_sel),
        .par_a_out(par_a_out), .par_a_oe(par_a_oe),
        .par_b_out(par_b_out), .par_b_oe(par_b_oe),
        .chk_a_n(chk_a_n), .chk_a_oe(chk_a_oe),
        .chk_b_n(chk_b_n), .chk_b_oe(chk_b_oe)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b (a=%02h pa=%0b b=%02h pb=%0b sel=%0b%0b%0b odd=%0b)",
                     req, what, act, exp, data_a, par_a, data_b, par_b,
                     func_sel_n, a2b_en_n, b2a_en_n, odd_sel);
        end
    endtask

    function automatic int ones(input logic [7:0] v);
        int n = 0;
        for (int i = 0; i < 8; i++) if (v[i]) n++;
        return n;
    endfunction

    // behavioural reference: good flag, and parity that completes the sense
    function automatic logic good(input logic [7:0] d, input logic p, input logic odd);
        int total = ones(d) + int'(p);
        return odd ? logic'(total % 2 == 1) : logic'(total % 2 == 0);
    endfunction

    function automatic logic fill(input logic [7:0] d, input logic odd);
        int n = ones(d) % 2;
        return odd ? logic'(n == 0) : logic'(n == 1);
    endfunction

    task automatic compare_all();
        string rs;
        logic e_pao, e_pbo, e_cao, e_cbo, e_pa, e_pb, e_ca, e_cb;
        e_pao = 0; e_pbo = 0; e_cao = 0; e_cbo = 0;
        e_pa = 0; e_pb = 0; e_ca = 0; e_cb = 0;
        rs = "R8";
        if (!func_sel_n) begin
            if (!a2b_en_n && b2a_en_n) begin
                rs = "R3"; e_cao = 1; e_ca = good(data_a, par_a, odd_sel);
                e_pbo = 1; e_pb = par_a;
            end else if (a2b_en_n && !b2a_en_n) begin
                rs = "R4"; e_cbo = 1; e_cb = good(data_b, par_b, odd_sel);
                e_pao = 1; e_pa = par_b;
            end else if (a2b_en_n && b2a_en_n) begin
                rs = "R5"; e_cao = 1; e_ca = good(data_a, par_a, odd_sel);
                e_cbo = 1; e_cb = good(data_b, par_b, odd_sel);
            end else begin
                rs = "R6"; e_pao = 1; e_pa = fill(data_a, odd_sel);
                e_pbo = 1; e_pb = fill(data_b, odd_sel);
            end
        end else begin
            rs = "R7";
            if (!a2b_en_n && b2a_en_n) begin e_pbo = 1; e_pb = par_a; end
            if (a2b_en_n && !b2a_en_n) begin e_pao = 1; e_pa = par_b; end
        end
        check(rs, "par_a_oe", par_a_oe, e_pao);
        check(rs, "par_b_oe", par_b_oe, e_pbo);
        check(rs, "chk_a_oe", chk_a_oe, e_cao);
        check(rs, "chk_b_oe", chk_b_oe, e_cbo);
        check(e_pao ? rs : "R8", "par_a_out", par_a_out, e_pa);
        check(e_pbo ? rs : "R8", "par_b_out", par_b_out, e_pb);
        // flag values: sense requirement R1 (even) or R2 (odd)
        check(e_cao ? (odd_sel ? "R2" : "R1") : "R8", "chk_a_n", chk_a_n, e_ca);
        check(e_cbo ? (odd_sel ? "R2" : "R1") : "R8", "chk_b_n", chk_b_n, e_cb);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // reset state: all-zero inputs are generate mode, even sense, zero data
        check("R6", "reset par_a_out", par_a_out, 1'b0);
        check("R6", "reset par_a_oe", par_a_oe, 1'b1);
        check("R6", "reset chk_a_oe", chk_a_oe, 1'b0);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int o = 0; o < 2; o++) begin
                for (int d = 0; d < 256; d++) begin
                    for (int p = 0; p < 4; p++) begin
                        @(posedge clk);
                        {func_sel_n, a2b_en_n, b2a_en_n} = 3'(m);
                        odd_sel = o[0];
                        data_a  = 8'(d);
                        data_b  = {data_a[3:0], data_a[7:4]} ^ 8'(8'hC3 + m);
                        {par_a, par_b} = 2'(p);
                        @(negedge clk);
                        compare_all();
                    end
                end
            end
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule